// File: doc/BRIEF.md
# Alignment Traceback Walker

This block recovers one optimal global alignment of two nucleotide strings of equal length after a score array has filled its grid. The array leaves behind, for every cell, a three-bit mask that marks which neighbours gave the cell its best score. The walker starts at the bottom-right cell and moves back toward the origin, one cell per clock. At each step it emits one aligned column: two letters, or one letter paired with a gap.

Rows of the grid index the second string (B) and columns index the first string (A). Cell (r, c) with r, c ≥ 1 compares A[c-1] with B[r-1]. Row 0 and column 0 form the boundary of the grid. Both strings and the mask memory are read through synchronous ports with one cycle of latency. The walker drives each read address from its next-state indices, so the data for the current cell is already present when that cell becomes current. Columns leave on a valid/ready stream, end of the alignment first, with a last flag on the column that reaches the origin.

Top module: `traceback_walker`

## Requirements
- R1: After reset the block is idle: `busy` and `col_valid` are low.
- R2: A `start` sampled high while idle begins a walk at cell (LENGTH, LENGTH). The first column is valid in the cycle after that edge.
- R3: The predecessor mask has bit 0 for diagonal, bit 1 for up (row-1) and bit 2 for left (col-1). When several bits are set, diagonal wins over up, and up wins over left. A zero mask is taken as diagonal.
- R4: A diagonal move emits A[c-1] on `col_a` and B[r-1] on `col_b`, then decrements both indices.
- R5: An up move emits a gap on `col_a` and B[r-1] on `col_b`, then decrements the row. A left move emits A[c-1] on `col_a` and a gap on `col_b`, then decrements the column.
- R6: On row 0 the walker always moves left, and on column 0 it always moves up, whatever the mask holds.
- R7: Letters use the 2-bit codes A=0, C=1, G=2, T=3 and appear as 3-bit outputs with bit 2 clear. The gap is 3'b100. No column carries two gaps.
- R8: `col_last` is high only on the column whose move reaches (0,0). After that column is accepted, the block is idle in the next cycle. A walk has between LENGTH and 2*LENGTH columns.
- R9: While `col_valid` is high and `col_ready` is low, the column, the last flag and the walk position hold unchanged.
- R10: With `col_ready` held high, one column is accepted every cycle until the last.
- R11: `start` is ignored while a walk is in progress.
- R12: For A=ACGTTGCAGG and B=GTTGCAGGAT with full-score predecessor masks, the columns read ACGTTGCAGG-- over --GTTGCAGGAT, emitted from the right end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| busy | output | 1 | A walk is in progress |
| a_addr | output | AW | Read address into string A |
| a_data | input | 2 | Letter of A, one cycle after the address |
| b_addr | output | AW | Read address into string B |
| b_data | input | 2 | Letter of B, one cycle after the address |
| ptr_row | output | IW | Row of the mask read |
| ptr_col | output | IW | Column of the mask read |
| ptr_mask | input | 3 | Predecessor mask, one cycle after the address |
| col_valid | output | 1 | An aligned column is offered |
| col_ready | input | 1 | The consumer accepts the column |
| col_a | output | 3 | A-side symbol of the column |
| col_b | output | 3 | B-side symbol of the column |
| col_last | output | 1 | This column reaches the origin |

## Verification
A start sampled at one rising edge makes the first column visible right after that edge. Each accepted column is followed by the next one at the following edge, and acceptance of the last column leaves the block idle one edge later. The bench drives `start` and `col_ready` and samples every output at the falling edge, so each comparison sees the state settled by the preceding rising edge. It compares each accepted column with a column list that it computes itself from the strings and masks, and checks that a stalled column is identical to the one seen a cycle earlier.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int CHAR_W = 2;
    localparam int SYM_W  = 3;

    localparam logic [SYM_W-1:0] GAP_SYM = 3'b100;

    localparam int PM_DIAG = 0;
    localparam int PM_UP   = 1;
    localparam int PM_LEFT = 2;

    typedef enum logic [1:0] {
        MV_DIAG = 2'd0,
        MV_UP   = 2'd1,
        MV_LEFT = 2'd2
    } move_e;

endpackage

// File: rtl/trace_move_sel.sv
module trace_move_sel
    import trace_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] row,
    input  logic [IW-1:0] col,
    input  logic [2:0]    mask,
    output move_e         move
);

    always_comb begin
        if (row == '0) begin
            move = MV_LEFT;
        end else if (col == '0) begin
            move = MV_UP;
        end else if (mask[PM_DIAG]) begin
            move = MV_DIAG;
        end else if (mask[PM_UP]) begin
            move = MV_UP;
        end else if (mask[PM_LEFT]) begin
            move = MV_LEFT;
        end else begin
            move = MV_DIAG;
        end
    end

endmodule

// File: rtl/trace_next_index.sv
module trace_next_index
    import trace_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] row,
    input  logic [IW-1:0] col,
    input  move_e         move,
    output logic [IW-1:0] nxt_row,
    output logic [IW-1:0] nxt_col,
    output logic          at_origin
);

    always_comb begin
        nxt_row = row;
        nxt_col = col;
        unique case (move)
            MV_DIAG: begin
                nxt_row = row - IW'(1);
                nxt_col = col - IW'(1);
            end
            MV_UP:   nxt_row = row - IW'(1);
            MV_LEFT: nxt_col = col - IW'(1);
            default: begin
                nxt_row = row;
                nxt_col = col;
            end
        endcase
        at_origin = (nxt_row == '0) && (nxt_col == '0);
    end

endmodule

// File: rtl/trace_column_fmt.sv
module trace_column_fmt
    import trace_pkg::*;
(
    input  move_e              move,
    input  logic [CHAR_W-1:0]  a_char,
    input  logic [CHAR_W-1:0]  b_char,
    output logic [SYM_W-1:0]   sym_a,
    output logic [SYM_W-1:0]   sym_b
);

    logic [SYM_W-1:0] a_letter;
    logic [SYM_W-1:0] b_letter;

    assign a_letter = {1'b0, a_char};
    assign b_letter = {1'b0, b_char};

    always_comb begin
        sym_a = a_letter;
        sym_b = b_letter;
        unique case (move)
            MV_UP:   sym_a = GAP_SYM;
            MV_LEFT: sym_b = GAP_SYM;
            default: begin
                sym_a = a_letter;
                sym_b = b_letter;
            end
        endcase
    end

endmodule

// File: rtl/traceback_walker.sv
module traceback_walker
    import trace_pkg::*;
#(
    parameter int LENGTH = 10,
    localparam int AW = (LENGTH > 1) ? $clog2(LENGTH) : 1,
    localparam int IW = $clog2(LENGTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] a_addr,
    input  logic [1:0]    a_data,
    output logic [AW-1:0] b_addr,
    input  logic [1:0]    b_data,
    output logic [IW-1:0] ptr_row,
    output logic [IW-1:0] ptr_col,
    input  logic [2:0]    ptr_mask,
    output logic          col_valid,
    input  logic          col_ready,
    output logic [2:0]    col_a,
    output logic [2:0]    col_b,
    output logic          col_last
);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] row;
        logic [IW-1:0] col;
    } walk_t;

    walk_t st_d, st_q;

    move_e         move;
    logic [IW-1:0] nxt_row;
    logic [IW-1:0] nxt_col;
    logic          at_origin;

    trace_move_sel #(.IW(IW)) u_sel (
        .row  (st_q.row),
        .col  (st_q.col),
        .mask (ptr_mask),
        .move (move)
    );

    trace_next_index #(.IW(IW)) u_step (
        .row       (st_q.row),
        .col       (st_q.col),
        .move      (move),
        .nxt_row   (nxt_row),
        .nxt_col   (nxt_col),
        .at_origin (at_origin)
    );

    trace_column_fmt u_fmt (
        .move   (move),
        .a_char (a_data),
        .b_char (b_data),
        .sym_a  (col_a),
        .sym_b  (col_b)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.row  = IW'(LENGTH);
                st_d.col  = IW'(LENGTH);
            end
        end else if (col_ready) begin
            st_d.row = nxt_row;
            st_d.col = nxt_col;
            if (at_origin) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read addresses follow the next-state indices so the synchronous
    // memories present the current cell's data without a bubble.
    always_comb begin
        ptr_row = st_d.row;
        ptr_col = st_d.col;
        a_addr  = (st_d.col == '0) ? '0 : AW'(st_d.col - IW'(1));
        b_addr  = (st_d.row == '0) ? '0 : AW'(st_d.row - IW'(1));
    end

    assign busy      = st_q.busy;
    assign col_valid = st_q.busy;
    assign col_last  = st_q.busy && at_origin;

endmodule

// File: rtl/traceback_walker_chk.sv
module traceback_walker_chk
    import trace_pkg::*;
#(
    parameter int LENGTH = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       col_valid,
    input logic       col_ready,
    input logic [2:0] col_a,
    input logic [2:0] col_b,
    input logic       col_last
);

    localparam int CW = $clog2(2 * LENGTH + 2);

    logic [CW-1:0] ncols_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            ncols_q <= '0;
        end else if (col_valid && col_ready) begin
            ncols_q <= ncols_q + CW'(1);
        end
    end

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_ready) |=> (col_valid && $stable(col_a) && $stable(col_b) && $stable(col_last)));

    a_r7_no_double_gap: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> !((col_a == GAP_SYM) && (col_b == GAP_SYM)));

    a_r7_gap_form: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> ((!col_a[2] || col_a == GAP_SYM) && (!col_b[2] || col_b == GAP_SYM)));

    a_r8_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_ready && col_last) |=> (!col_valid && !busy));

    a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_ready && !col_last) |=> col_valid);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (int'(ncols_q) < 2 * LENGTH));

endmodule

bind traceback_walker traceback_walker_chk #(.LENGTH(LENGTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .col_valid (col_valid),
    .col_ready (col_ready),
    .col_a     (col_a),
    .col_b     (col_b),
    .col_last  (col_last)
);

// File: tb/traceback_walker_bench.sv
module traceback_walker_bench;

    localparam int LEN = 10;
    localparam int AW  = $clog2(LEN);
    localparam int IW  = $clog2(LEN + 1);
    localparam logic [2:0] GAP = 3'b100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy;
    logic [AW-1:0] a_addr;
    logic [1:0]    a_data;
    logic [AW-1:0] b_addr;
    logic [1:0]    b_data;
    logic [IW-1:0] ptr_row;
    logic [IW-1:0] ptr_col;
    logic [2:0]    ptr_mask;
    logic          col_valid;
    logic          col_ready = 1'b0;
    logic [2:0]    col_a;
    logic [2:0]    col_b;
    logic          col_last;

    int checks = 0;
    int failures = 0;

    logic [1:0] sa [LEN];
    logic [1:0] sb [LEN];
    logic [2:0] mk [LEN+1][LEN+1];
    int         hs [LEN+1][LEN+1];

    logic [2:0] exp_a [2*LEN];
    logic [2:0] exp_b [2*LEN];
    int         n_exp;

    logic [2:0] got_a [2*LEN];
    logic [2:0] got_b [2*LEN];
    int         n_got;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        a_data   <= sa[a_addr];
        b_data   <= sb[b_addr];
        ptr_mask <= mk[ptr_row][ptr_col];
    end

    traceback_walker #(.LENGTH(LEN)) u_traceback_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .a_addr(a_addr), .a_data(a_data), .b_addr(b_addr), .b_data(b_data),
        .ptr_row(ptr_row), .ptr_col(ptr_col), .ptr_mask(ptr_mask),
        .col_valid(col_valid), .col_ready(col_ready),
        .col_a(col_a), .col_b(col_b), .col_last(col_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [1:0] code_of(input byte ch);
        case (ch)
            "A": return 2'd0;
            "C": return 2'd1;
            "G": return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Full score grid with every optimal predecessor marked; boundary masks are random garbage.
    task automatic fill_scores();
        for (int r = 0; r <= LEN; r++) begin
            for (int c = 0; c <= LEN; c++) begin
                if (r == 0) begin
                    hs[r][c] = -c;
                    mk[r][c] = 3'($urandom);
                end else if (c == 0) begin
                    hs[r][c] = -r;
                    mk[r][c] = 3'($urandom);
                end else begin
                    int dg, up, lf, best;
                    dg = hs[r-1][c-1] + ((sa[c-1] == sb[r-1]) ? 1 : -1);
                    up = hs[r-1][c] - 1;
                    lf = hs[r][c-1] - 1;
                    best = dg;
                    if (up > best) best = up;
                    if (lf > best) best = lf;
                    hs[r][c] = best;
                    mk[r][c] = {(lf == best), (up == best), (dg == best)};
                end
            end
        end
    endtask

    // Expected column list from the stated move rules (R3-R6).
    task automatic build_expected();
        int r, c;
        r = LEN;
        c = LEN;
        n_exp = 0;
        while (!(r == 0 && c == 0)) begin
            int mv;
            if (r == 0) mv = 2;
            else if (c == 0) mv = 1;
            else if (mk[r][c][0]) mv = 0;
            else if (mk[r][c][1]) mv = 1;
            else if (mk[r][c][2]) mv = 2;
            else mv = 0;
            if (mv == 0) begin
                exp_a[n_exp] = {1'b0, sa[c-1]};
                exp_b[n_exp] = {1'b0, sb[r-1]};
                r--; c--;
            end else if (mv == 1) begin
                exp_a[n_exp] = GAP;
                exp_b[n_exp] = {1'b0, sb[r-1]};
                r--;
            end else begin
                exp_a[n_exp] = {1'b0, sa[c-1]};
                exp_b[n_exp] = GAP;
                c--;
            end
            n_exp++;
        end
    endtask

    task automatic run_walk(input bit rand_ready, input bit poke_start);
        bit done;
        bit stalled;
        logic [2:0] pa, pb;
        logic pl;
        int cyc;
        n_got = 0;
        done = 0;
        stalled = 0;
        pa = '0; pb = '0; pl = 1'b0;
        cyc = 0;
        start = 1'b1;
        col_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(col_valid === 1'b1 && busy === 1'b1, "R2 valid one cycle after start", int'(col_valid), 1);
        while (!done && cyc < 8 * LEN) begin
            bit rdy;
            cyc++;
            if (col_valid !== 1'b1) begin
                chk(0, "R10 column missing mid-walk", int'(col_valid), 1);
                done = 1;
            end else begin
                if (stalled) begin
                    chk(col_a === pa && col_b === pb && col_last === pl,
                        "R9 stalled column held", int'({col_a, col_b}), int'({pa, pb}));
                end
                rdy = rand_ready ? (($urandom % 4) != 0) : 1'b1;
                start = (poke_start && n_got == 2) ? 1'b1 : 1'b0;
                if (rdy) begin
                    if (n_got < 2 * LEN) begin
                        got_a[n_got] = col_a;
                        got_b[n_got] = col_b;
                    end
                    if (n_got < n_exp) begin
                        chk(col_a === exp_a[n_got], "R4 R5 R6 col_a", int'(col_a), int'(exp_a[n_got]));
                        chk(col_b === exp_b[n_got], "R4 R5 R6 col_b", int'(col_b), int'(exp_b[n_got]));
                        chk(col_last === (n_got == n_exp - 1), "R8 last flag", int'(col_last),
                            int'(n_got == n_exp - 1));
                    end
                    if (col_last === 1'b1) done = 1;
                    n_got++;
                end
                stalled = !rdy;
                pa = col_a; pb = col_b; pl = col_last;
                col_ready = rdy;
            end
            @(negedge clk);
            start = 1'b0;
        end
        col_ready = 1'b0;
        chk(col_valid === 1'b0 && busy === 1'b0, "R8 idle after last", int'(busy), 0);
        chk(n_got == n_exp, poke_start ? "R11 start ignored while busy" : "R8 column count",
            n_got, n_exp);
        chk(n_exp >= LEN && n_exp <= 2 * LEN, "R8 count bound", n_exp, LEN);
        if (!rand_ready) begin
            chk(cyc == n_exp, "R10 one column per cycle", cyc, n_exp);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        string ea, eb;
        void'($urandom(32'd20240611));
        for (int r = 0; r <= LEN; r++)
            for (int c = 0; c <= LEN; c++)
                mk[r][c] = 3'd0;
        for (int i = 0; i < LEN; i++) begin
            sa[i] = 2'd0;
            sb[i] = 2'd0;
        end
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && col_valid === 1'b0, "R1 idle in reset", int'(col_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && col_valid === 1'b0, "R1 idle after reset", int'(busy), 0);

        // R12: known pair, ready held high.
        ea = "ACGTTGCAGG";
        eb = "GTTGCAGGAT";
        for (int i = 0; i < LEN; i++) begin
            sa[i] = code_of(ea[i]);
            sb[i] = code_of(eb[i]);
        end
        fill_scores();
        build_expected();
        run_walk(1'b0, 1'b0);
        begin
            string ta, tb2;
            ta  = "ACGTTGCAGG--";
            tb2 = "--GTTGCAGGAT";
            chk(n_got == 12, "R12 column count", n_got, 12);
            for (int k = 0; k < 12 && k < n_got; k++) begin
                logic [2:0] wa, wb;
                wa = (ta[11-k] == "-") ? GAP : {1'b0, code_of(ta[11-k])};
                wb = (tb2[11-k] == "-") ? GAP : {1'b0, code_of(tb2[11-k])};
                chk(got_a[k] === wa && got_b[k] === wb, "R12 aligned column",
                    int'({got_a[k], got_b[k]}), int'({wa, wb}));
            end
        end

        // R3 R6: all-left masks force a corner path of 2*LEN columns.
        for (int r = 0; r <= LEN; r++)
            for (int c = 0; c <= LEN; c++)
                mk[r][c] = 3'b100;
        build_expected();
        chk(n_exp == 2 * LEN, "R6 corner path length", n_exp, 2 * LEN);
        run_walk(1'b1, 1'b0);

        // R3: zero masks behave as diagonal.
        for (int r = 0; r <= LEN; r++)
            for (int c = 0; c <= LEN; c++)
                mk[r][c] = 3'b000;
        build_expected();
        chk(n_exp == LEN, "R3 zero mask diagonal", n_exp, LEN);
        run_walk(1'b0, 1'b1);

        // R3 R4 R5 R7 R9: random strings with scored masks and random masks.
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < LEN; i++) begin
                sa[i] = 2'($urandom);
                sb[i] = 2'($urandom);
            end
            if (t % 2 == 0) begin
                fill_scores();
            end else begin
                for (int r = 0; r <= LEN; r++)
                    for (int c = 0; c <= LEN; c++)
                        mk[r][c] = 3'($urandom);
            end
            build_expected();
            run_walk(t % 3 != 0, t % 5 == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule